// File: doc/BRIEF.md
# Indirect Configuration Register Access Port

This block lets software on the system bus reach a bank of 64 configuration words that sits behind a narrow private port. It exposes three bus registers: one for command and address, one for write data and one for read data. Software never touches the bank directly. It posts a command, and a small sequencer carries out the access on the bank port. That port has an address, byte enables, single-cycle read and write strobes, and read data that returns a fixed number of cycles after the read strobe.

A read starts as soon as the command register is written with the read command. Software may read the read-data register on the very next bus cycle. The port answers with retry until the fetched word has arrived, then completes the read with that word, so no status polling is needed. A write is a two-step operation. The command register is first written with the write command and active-low byte enables, and the bank is written only when the write-data register is then written. While the sequencer is working, every bus access to the three registers is retried. Only function number 0 exists. A command carrying any other function number never reaches the bank, and a read command of that kind makes the read-data register return all ones.

Top module: `cfg_indirect_port`

## Requirements
- R1: After reset the command, write-data and read-data registers read as zero, no access is retried, and neither bank strobe is active.
- R2: Writing register 0 (command) with bit 7 = 0 (read), function bits [14:12] = 0 and word address in bits [5:0] raises `bk_rd` for exactly one cycle, on the cycle after the accepting edge, with `bk_addr` equal to that address. The word returned LAT cycles later is loaded into the read-data register.
- R3: While the sequencer is busy (from the cycle after a launch until its access is finished), every bus access is answered with `bus_retry`, and no register changes. `bus_retry` is never raised without `bus_sel`.
- R4: A read of register 2 (read data) presented on the cycle right after a read command is retried exactly LAT+1 times. It then completes with the fetched word.
- R5: A command write with bit 7 = 1 (write) and function 0 causes no bank write on its own. A following write to register 1 (write data) raises `bk_wr` for exactly one cycle, on the next cycle, with the commanded address and the write-data value.
- R6: The byte enables are active-low in command bits [11:8], with bit 8 for data byte 0. A bank byte is updated only where its enable bit is 0.
- R7: A command with a nonzero function number in bits [14:12] produces no bank strobe. For a read, the read-data register becomes all ones with no retry. For a write, the following write-data write is not launched.
- R8: Reading register 2 when no read is in progress returns the last loaded value without retry.
- R9: One write command launches at most one bank write. A write-data write with no write command armed only stores the data.
- R10: Register 0 and register 1 read back their last written value (command bits [14:0], upper bits zero). Register 3 reads zero. Bus writes to register 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access presented this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 2 | Register select: 0 command, 1 write data, 2 read data |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Bus read data, valid when the access is not retried |
| bus_retry | output | 1 | Access not taken; the master must repeat it |
| bk_addr | output | ADDR_W | Bank word address |
| bk_be | output | BE_W | Bank byte enables, active high |
| bk_wr | output | 1 | Bank write strobe |
| bk_rd | output | 1 | Bank read strobe |
| bk_wdata | output | DATA_W | Bank write data |
| bk_rdata | input | DATA_W | Bank read data, valid LAT cycles after `bk_rd` |

## Verification
The vector table alternates full-word writes, partial writes with mixed byte-enable patterns (alternating bytes, a single top byte, no bytes at all) and read-backs. These cases separate a correct byte-lane mapping from an inverted or shifted one, and separate a captured word from a stale or early-sampled one. Reads are always issued immediately after their command. The exact retry count therefore shows whether the busy window matches the bank latency. Directed cases then compare a write command with and without a following data write, a repeated data write, a nonzero function number and accesses made during the busy window, so that each ignore rule is checked at the ports.

// File: rtl/cfgp_pkg.sv
// Package: shared encodings for the indirect configuration port.
// Assumes the command word fields fit below bit 15 of the bus word.
package cfgp_pkg;

    // Bus register select values
    localparam logic [1:0] REG_CMD = 2'd0;
    localparam logic [1:0] REG_WD  = 2'd1;
    localparam logic [1:0] REG_RD  = 2'd2;

    // Command word field positions (decoded by the sequencer path)
    localparam int ADDR_LSB = 0;
    localparam int WR_BIT   = 7;
    localparam int BE_LSB   = 8;
    localparam int FUNC_LSB = 12;

    // Sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RD_REQ,
        SQ_RD_WAIT,
        SQ_WR_REQ
    } sq_state_t;

endpackage

// File: rtl/cfgp_regs.sv
// Module: bus-side register file of the configuration port.
// Holds the command, write-data and read-data registers, decodes bus
// accesses, answers retry while the sequencer is busy and issues launch
// pulses. Assumes one bus access per cycle and DATA_W >= FUNC_LSB+FUNC_W.
module cfgp_regs
    import cfgp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int BE_W   = 4,
    parameter int FUNC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_reg,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_retry,
    input  logic              busy,
    input  logic              cap_valid,
    input  logic [DATA_W-1:0] cap_data,
    output logic              launch_rd,
    output logic              launch_wr,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [BE_W-1:0]   tgt_be_n,
    output logic [DATA_W-1:0] wd_out
);

    localparam int CMD_W = FUNC_LSB + FUNC_W;

    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rd_q;
    logic              armed_q;
    logic              accept;
    logic              cmd_hit;
    logic              wd_hit;
    logic              func_ok;
    logic              is_wr_cmd;

    // Decode of the presented access
    always_comb begin
        bus_retry = bus_sel & busy;
        accept    = bus_sel & ~busy;
        cmd_hit   = accept & bus_wr & (bus_reg == REG_CMD);
        wd_hit    = accept & bus_wr & (bus_reg == REG_WD);
        func_ok   = (bus_wdata[FUNC_LSB +: FUNC_W] == '0);
        is_wr_cmd = bus_wdata[WR_BIT];
        launch_rd = cmd_hit & ~is_wr_cmd & func_ok;
        launch_wr = wd_hit & armed_q;
    end

    // Command register and write-arm flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            armed_q <= 1'b0;
        end else if (cmd_hit) begin
            cmd_q   <= bus_wdata[CMD_W-1:0];
            armed_q <= is_wr_cmd & func_ok;
        end else if (wd_hit) begin
            armed_q <= 1'b0;
        end
    end

    // Write-data register
    always_ff @(posedge clk) begin
        if (!rst_n)      wd_q <= '0;
        else if (wd_hit) wd_q <= bus_wdata;
    end

    // Read-data register: fetched word, or all ones for a foreign function
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (cap_valid)
            rd_q <= cap_data;
        else if (cmd_hit && !is_wr_cmd && !func_ok)
            rd_q <= '1;
    end

    // Read-back multiplexer
    always_comb begin
        case (bus_reg)
            REG_CMD: bus_rdata = DATA_W'(cmd_q);
            REG_WD:  bus_rdata = wd_q;
            REG_RD:  bus_rdata = rd_q;
            default: bus_rdata = '0;
        endcase
    end

    // Target fields handed to the sequencer
    always_comb begin
        tgt_addr = cmd_q[ADDR_LSB +: ADDR_W];
        tgt_be_n = cmd_q[BE_LSB +: BE_W];
        wd_out   = wd_q;
    end

endmodule

// File: rtl/cfgp_seq.sv
// Module: bank-side sequencer of the configuration port.
// Turns launch pulses into one-cycle bank strobes. For a read it waits a
// fixed LAT cycles and then presents the returned word for capture.
// Assumes LAT >= 1 and that launches arrive only while idle.
module cfgp_seq
    import cfgp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int BE_W   = 4,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_rd,
    input  logic              launch_wr,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [BE_W-1:0]   tgt_be_n,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              cap_valid,
    output logic [DATA_W-1:0] cap_data,
    output logic [ADDR_W-1:0] bk_addr,
    output logic [BE_W-1:0]   bk_be,
    output logic              bk_wr,
    output logic              bk_rd,
    output logic [DATA_W-1:0] bk_wdata,
    input  logic [DATA_W-1:0] bk_rdata
);

    localparam int CNT_W = (LAT < 2) ? 1 : $clog2(LAT);
    localparam logic [CNT_W-1:0] CNT_START = CNT_W'(LAT - 1);

    sq_state_t        state_q;
    logic [CNT_W-1:0] cnt_q;

    // State and latency counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (launch_rd)      state_q <= SQ_RD_REQ;
                    else if (launch_wr) state_q <= SQ_WR_REQ;
                end
                SQ_RD_REQ: begin
                    state_q <= SQ_RD_WAIT;
                    cnt_q   <= CNT_START;
                end
                SQ_RD_WAIT: begin
                    if (cnt_q == '0) state_q <= SQ_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Strobes and status from the current state
    always_comb begin
        busy      = (state_q != SQ_IDLE);
        bk_rd     = (state_q == SQ_RD_REQ);
        bk_wr     = (state_q == SQ_WR_REQ);
        cap_valid = (state_q == SQ_RD_WAIT) && (cnt_q == '0);
        cap_data  = bk_rdata;
        bk_addr   = tgt_addr;
        bk_wdata  = wdata;
    end

    // Per-byte conversion of active-low enables to active-high
    for (genvar b = 0; b < BE_W; b++) begin : g_be
        assign bk_be[b] = ~tgt_be_n[b];
    end

endmodule

// File: rtl/cfg_indirect_port.sv
// Module: top of the indirect configuration register access port.
// Connects the bus-side register file to the bank sequencer. Assumes the
// bank returns read data exactly LAT cycles after a read strobe.
module cfg_indirect_port #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int BE_W   = 4,
    parameter int FUNC_W = 3,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_reg,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_retry,
    output logic [ADDR_W-1:0] bk_addr,
    output logic [BE_W-1:0]   bk_be,
    output logic              bk_wr,
    output logic              bk_rd,
    output logic [DATA_W-1:0] bk_wdata,
    input  logic [DATA_W-1:0] bk_rdata
);

    logic              busy;
    logic              cap_valid;
    logic [DATA_W-1:0] cap_data;
    logic              launch_rd;
    logic              launch_wr;
    logic [ADDR_W-1:0] tgt_addr;
    logic [BE_W-1:0]   tgt_be_n;
    logic [DATA_W-1:0] wd_val;

    cfgp_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BE_W(BE_W), .FUNC_W(FUNC_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_retry(bus_retry),
        .busy(busy), .cap_valid(cap_valid), .cap_data(cap_data),
        .launch_rd(launch_rd), .launch_wr(launch_wr),
        .tgt_addr(tgt_addr), .tgt_be_n(tgt_be_n), .wd_out(wd_val)
    );

    cfgp_seq #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BE_W(BE_W), .LAT(LAT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .launch_rd(launch_rd), .launch_wr(launch_wr),
        .tgt_addr(tgt_addr), .tgt_be_n(tgt_be_n), .wdata(wd_val),
        .busy(busy), .cap_valid(cap_valid), .cap_data(cap_data),
        .bk_addr(bk_addr), .bk_be(bk_be), .bk_wr(bk_wr), .bk_rd(bk_rd),
        .bk_wdata(bk_wdata), .bk_rdata(bk_rdata)
    );

endmodule

// File: rtl/cfgp_chk.sv
// Module: protocol checker for the configuration port, bound to the top.
// Watches bus retry and bank strobes only; assumes synchronous reset.
module cfgp_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_sel,
    input logic bus_retry,
    input logic bk_rd,
    input logic bk_wr
);

    // R3
    retry_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_retry |-> bus_sel);

    // R3
    retry_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bk_rd) |-> bus_retry);

    // R3
    retry_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bk_wr) |-> bus_retry);

    // R2
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bk_rd |=> !bk_rd);

    // R4
    read_wait_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bk_rd |=> (!bus_sel || bus_retry));

    // R5
    write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bk_wr |=> !bk_wr);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bk_rd && bk_wr));

endmodule

bind cfg_indirect_port cfgp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_retry(bus_retry),
    .bk_rd(bk_rd), .bk_wr(bk_wr)
);

// File: tb/cfg_indirect_port_bench.sv
// Bench: vector table of bank writes and reads, then directed corner cases.
module cfg_indirect_port_bench;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_reg = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_retry;
    logic [5:0]  bk_addr;
    logic [3:0]  bk_be;
    logic        bk_wr;
    logic        bk_rd;
    logic [31:0] bk_wdata;
    logic [31:0] bk_rdata;

    int checks = 0;
    int fails = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    cfg_indirect_port u_cfg_indirect_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_retry(bus_retry), .bk_addr(bk_addr), .bk_be(bk_be),
        .bk_wr(bk_wr), .bk_rd(bk_rd), .bk_wdata(bk_wdata),
        .bk_rdata(bk_rdata)
    );

    // Behavioural configuration bank with fixed read latency
    logic [31:0] mem [64];
    logic [31:0] pipe [LAT];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= '0;
            for (int i = 0; i < LAT; i++) pipe[i] <= 32'h0BAD0BAD;
        end else begin
            if (bk_wr)
                for (int b = 0; b < 4; b++)
                    if (bk_be[b]) mem[bk_addr][8*b +: 8] <= bk_wdata[8*b +: 8];
            pipe[0] <= bk_rd ? mem[bk_addr] : 32'h0BAD0BAD;
            for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
        end
    end
    assign bk_rdata = pipe[LAT-1];

    // Strobe counters seen at the bank port
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end else begin
            if (bk_rd) rd_cnt <= rd_cnt + 1;
            if (bk_wr) wr_cnt <= wr_cnt + 1;
        end
    end

    function automatic logic [31:0] mk_cmd(input logic [2:0] fn,
            input logic [3:0] be_n, input logic wr, input logic [5:0] a);
        return {17'b0, fn, be_n, wr, 1'b0, a};
    endfunction

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one access, repeating it while retried
    task automatic access(input logic wr, input logic [1:0] rg,
            input logic [31:0] d, output logic [31:0] rd, output int tries);
        logic done = 1'b0;
        tries = 0;
        rd = '0;
        while (!done) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = wr; bus_reg = rg; bus_wdata = d;
            #1;
            if (!bus_retry) begin
                rd = bus_rdata;
                done = 1'b1;
            end else begin
                tries++;
            end
            @(posedge clk);
            #1 bus_sel = 1'b0;
        end
    endtask

    // Present one access for a single cycle
    task automatic try_once(input logic wr, input logic [1:0] rg,
            input logic [31:0] d, output logic retry);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_reg = rg; bus_wdata = d;
        #1 retry = bus_retry;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // op, addr, be_n, data, expected
    localparam logic [74:0] VEC [10] = '{
        {1'b1, 6'd5,  4'b0000, 32'h12345678, 32'h0},
        {1'b0, 6'd5,  4'b0000, 32'h0,        32'h12345678},
        {1'b1, 6'd63, 4'b0000, 32'hDEADBEEF, 32'h0},
        {1'b1, 6'd63, 4'b1010, 32'h11223344, 32'h0},
        {1'b0, 6'd63, 4'b0000, 32'h0,        32'hDE22BE44},
        {1'b0, 6'd5,  4'b0000, 32'h0,        32'h12345678},
        {1'b1, 6'd0,  4'b0111, 32'hAABBCCDD, 32'h0},
        {1'b0, 6'd0,  4'b0000, 32'h0,        32'hAA000000},
        {1'b1, 6'd5,  4'b1111, 32'hFFFFFFFF, 32'h0},
        {1'b0, 6'd5,  4'b0000, 32'h0,        32'h12345678}
    };

    initial begin
        logic [31:0] rd;
        int tries;
        int c0;
        logic rt;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int r = 0; r < 3; r++) begin
            access(1'b0, 2'(r), 32'h0, rd, tries);
            chk("R1 reg after reset", rd, 32'h0);
            chk("R1 no retry after reset", 32'(tries), 32'd0);
        end
        chk("R1 no bank strobes", 32'(rd_cnt + wr_cnt), 32'd0);

        // Vector table: R2 R4 R5 R6
        for (int v = 0; v < 10; v++) begin
            if (VEC[v][74]) begin
                c0 = wr_cnt;
                access(1'b1, 2'd0, mk_cmd(3'd0, VEC[v][67:64], 1'b1, VEC[v][73:68]), rd, tries);
                access(1'b1, 2'd1, VEC[v][63:32], rd, tries);
                idle(3);
                chk("R5 one bank write", 32'(wr_cnt - c0), 32'd1);
            end else begin
                c0 = rd_cnt;
                access(1'b1, 2'd0, mk_cmd(3'd0, 4'b0, 1'b0, VEC[v][73:68]), rd, tries);
                access(1'b0, 2'd2, 32'h0, rd, tries);
                chk("R2 R6 fetched word", rd, VEC[v][31:0]);
                chk("R4 retry count", 32'(tries), 32'(LAT + 1));
                chk("R2 one bank read", 32'(rd_cnt - c0), 32'd1);
            end
        end

        // R8 repeated read with nothing pending
        access(1'b0, 2'd2, 32'h0, rd, tries);
        chk("R8 last value", rd, 32'h12345678);
        chk("R8 no retry", 32'(tries), 32'd0);

        // R3 accesses during busy window
        access(1'b1, 2'd0, mk_cmd(3'd0, 4'b0, 1'b0, 6'd63), rd, tries);
        try_once(1'b1, 2'd1, 32'h55555555, rt);
        chk("R3 write retried while busy", 32'(rt), 32'd1);
        try_once(1'b0, 2'd0, 32'h0, rt);
        chk("R3 read retried while busy", 32'(rt), 32'd1);
        idle(4);
        access(1'b0, 2'd1, 32'h0, rd, tries);
        chk("R3 write data unchanged", rd, 32'hFFFFFFFF);
        access(1'b0, 2'd2, 32'h0, rd, tries);
        chk("R3 fetched after busy", rd, 32'hDE22BE44);

        // R5 R9 arming rules
        c0 = wr_cnt;
        access(1'b1, 2'd0, mk_cmd(3'd0, 4'b0, 1'b1, 6'd1), rd, tries);
        idle(3);
        chk("R5 command alone no write", 32'(wr_cnt - c0), 32'd0);
        access(1'b1, 2'd1, 32'h0F0F0F0F, rd, tries);
        idle(3);
        chk("R5 data write launches", 32'(wr_cnt - c0), 32'd1);
        access(1'b1, 2'd1, 32'h77777777, rd, tries);
        idle(3);
        chk("R9 second data write not launched", 32'(wr_cnt - c0), 32'd1);
        access(1'b1, 2'd0, mk_cmd(3'd0, 4'b0, 1'b0, 6'd1), rd, tries);
        access(1'b0, 2'd2, 32'h0, rd, tries);
        chk("R9 bank holds first data", rd, 32'h0F0F0F0F);

        // R7 foreign function number
        c0 = rd_cnt;
        access(1'b1, 2'd0, mk_cmd(3'd1, 4'b0, 1'b0, 6'd5), rd, tries);
        access(1'b0, 2'd2, 32'h0, rd, tries);
        chk("R7 read returns ones", rd, 32'hFFFFFFFF);
        chk("R7 read not retried", 32'(tries), 32'd0);
        chk("R7 no bank read", 32'(rd_cnt - c0), 32'd0);
        c0 = wr_cnt;
        access(1'b1, 2'd0, mk_cmd(3'd2, 4'b0, 1'b1, 6'd5), rd, tries);
        access(1'b1, 2'd1, 32'h00000000, rd, tries);
        idle(3);
        chk("R7 no bank write", 32'(wr_cnt - c0), 32'd0);
        access(1'b1, 2'd0, mk_cmd(3'd0, 4'b0, 1'b0, 6'd5), rd, tries);
        access(1'b0, 2'd2, 32'h0, rd, tries);
        chk("R7 bank word untouched", rd, 32'h12345678);

        // R10 register map
        access(1'b1, 2'd2, 32'h13579BDF, rd, tries);
        access(1'b0, 2'd2, 32'h0, rd, tries);
        chk("R10 read data not writable", rd, 32'h12345678);
        access(1'b0, 2'd3, 32'h0, rd, tries);
        chk("R10 register 3 zero", rd, 32'h0);
        access(1'b1, 2'd0, mk_cmd(3'd0, 4'h5, 1'b1, 6'h2A), rd, tries);
        access(1'b0, 2'd0, 32'h0, rd, tries);
        chk("R10 command read-back", rd, mk_cmd(3'd0, 4'h5, 1'b1, 6'h2A));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1-run actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule